// File: doc/BRIEF.md
# State Occupancy Profiler with RAM-Held Counters

This block watches the state code of another state machine and counts, per state, the clock cycles that machine spends there. Since a machine sits in exactly one state per cycle, at most one counter changes per cycle. That lets all the counters share one memory array, which maps onto a block RAM, instead of one flip-flop register per state. A two-stage read-modify-write pipeline does the update. When the same state repeats on consecutive cycles, the value still in flight is forwarded into the next increment.

A host-side reader fetches any counter with a one-cycle request. It can do so after the monitored run ends, or sample counters while counting goes on. A total-cycle counter runs beside the state counters, so each state's count can be turned into a fraction of elapsed time. Control strobes clear all counters, halt counting and resume it. A clear sweeps the memory one address per cycle and raises a busy flag while the sweep runs.

With the default width the block watches a pipeline controller with four states: idle (code 0), initialise (code 1), run (code 2) and flush (code 3).

Top module: `state_occupancy_profiler`

## Requirements
- R1: When `st_valid` is high, counting is enabled and no sweep is running at a rising edge, the counter whose address equals `st_code` increases by exactly one. All other counters keep their values.
- R2: A rising edge where `st_valid` is low changes no state counter.
- R3: A state code repeated on consecutive edges, or interleaved with other codes, adds one per edge. No increment is lost to the pipeline's memory latency.
- R4: A state counter that holds all ones (2^CNT_W-1) stays at all ones. It never wraps.
- R5: A `halt_req` pulse sets `counting` low. After that, neither the state counters nor `cycle_total` change until a `resume_req` pulse, which sets `counting` high again. `halt_req` wins if both are high at once.
- R6: A `clr_req` pulse sets every state counter and `cycle_total` to zero. `busy` is high for exactly 2^STATE_W cycles after the pulse's edge. Valid states presented on the clear edge or while `busy` is high are not counted.
- R7: After reset, `busy` is high for 2^STATE_W cycles. After that, every state counter reads zero, `cycle_total` starts from zero and `counting` is high.
- R8: `rd_req` high at an edge gives `rd_ack` high in the next cycle. `rd_data` then holds the counter at `rd_addr`, including every event sampled at earlier edges, even one whose memory write lands on that same edge. Reads never disturb counting.
- R9: `cycle_total` increases by one at every edge where counting is enabled and `busy` is low, whatever `st_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Qualifies `st_code` for this cycle |
| st_code | input | STATE_W | Current state of the watched machine |
| clr_req | input | 1 | Pulse: zero all counters and start the sweep |
| halt_req | input | 1 | Pulse: stop counting |
| resume_req | input | 1 | Pulse: restart counting |
| rd_req | input | 1 | Host read request |
| rd_addr | input | STATE_W | Counter to read |
| rd_ack | output | 1 | Read data valid |
| rd_data | output | CNT_W | Counter value read |
| cycle_total | output | CYC_W | Cycles counted while enabled and not sweeping |
| busy | output | 1 | Clear sweep in progress |
| counting | output | 1 | Counting enabled |

## Verification
Several properties are checked on every cycle by assertions:
- no incremented counter value is ever zero;
- a forwarded increment never falls below the value it was built on;
- a sweep ends only on the last address;
- the update pipeline never writes while a sweep owns the memory;
- `cycle_total` holds still while halted;
- every read request is acknowledged one cycle later.

Other behaviour only the directed scenarios can show:
- the exact per-state tallies for mixed, repeated and gapped patterns;
- a mid-run read that has to pick up a value being written on the same edge;
- saturation after more events than the counter can hold;
- the exact sweep length, and that states presented during a clear are dropped.

// File: rtl/prof_pkg.sv
package prof_pkg;
  localparam int unsigned DEF_STATE_W = 2;

  // Default watched controller: four states, one counter each.
  typedef enum logic [1:0] {
    PC_IDLE  = 2'd0,
    PC_INIT  = 2'd1,
    PC_RUN   = 2'd2,
    PC_FLUSH = 2'd3
  } pipe_state_e;
endpackage

// File: rtl/prof_ram.sv
// One write port, two synchronous read ports, read-before-write.
module prof_ram #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/prof_sweep.sv
// Clear controller: zeroes one address per cycle while busy.
module prof_sweep #(
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) busy <= 1'b0;
    end
  end

  AST_SWEEP_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(ptr) == LAST) else $error("sweep ended early"); // R6
endmodule

// File: rtl/prof_update.sv
// Two-stage read-modify-write with forwarding and saturation.
module prof_update #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          ev,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] rd_val,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_val
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic          s1_vld, s2_vld;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [DW-1:0] s2_val;
  logic          fwd;
  logic [DW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= ev;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= ev_addr;
    s2_addr <= s1_addr;
    s2_val  <= wr_val;
  end

  // The memory read for stage 1 was taken before stage 2's write landed.
  always_comb begin
    fwd    = s2_vld && (s2_addr == s1_addr);
    base   = fwd ? s2_val : rd_val;
    wr_val = (base == CNT_MAX) ? base : base + 1'b1;
  end

  assign wr_en   = s1_vld;
  assign wr_addr = s1_addr;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> wr_val != '0) else $error("counter wrapped"); // R4
  AST_FWD_MONO: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s2_vld && s1_addr == s2_addr) |-> wr_val >= s2_val)
    else $error("forwarded count went down"); // R3
endmodule

// File: rtl/state_occupancy_profiler.sv
module state_occupancy_profiler
  import prof_pkg::*;
#(
  parameter int unsigned STATE_W = DEF_STATE_W,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CYC_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               st_valid,
  input  logic [STATE_W-1:0] st_code,
  input  logic               clr_req,
  input  logic               halt_req,
  input  logic               resume_req,
  input  logic               rd_req,
  input  logic [STATE_W-1:0] rd_addr,
  output logic               rd_ack,
  output logic [CNT_W-1:0]   rd_data,
  output logic [CYC_W-1:0]   cycle_total,
  output logic               busy,
  output logic               counting
);
  logic               ev;
  logic [STATE_W-1:0] sweep_ptr;
  logic               upd_we;
  logic [STATE_W-1:0] upd_wa;
  logic [CNT_W-1:0]   upd_wd;
  logic               mem_we;
  logic [STATE_W-1:0] mem_wa;
  logic [CNT_W-1:0]   mem_wd;
  logic [CNT_W-1:0]   ra_q, rb_q;
  logic               hit_q;
  logic [CNT_W-1:0]   hit_val_q;

  always_ff @(posedge clk) begin
    if (rst)             counting <= 1'b1;
    else if (halt_req)   counting <= 1'b0;
    else if (resume_req) counting <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_req)          cycle_total <= '0;
    else if (counting && !busy)  cycle_total <= cycle_total + 1'b1;
  end

  assign ev = st_valid && counting && !busy;

  prof_sweep #(.AW(STATE_W)) u_sweep (
    .clk(clk), .rst(rst), .start(clr_req), .busy(busy), .ptr(sweep_ptr)
  );

  prof_update #(.AW(STATE_W), .DW(CNT_W)) u_update (
    .clk(clk), .rst(rst), .flush(clr_req), .ev(ev), .ev_addr(st_code),
    .rd_val(ra_q), .wr_en(upd_we), .wr_addr(upd_wa), .wr_val(upd_wd)
  );

  // The sweep owns the write port while busy.
  always_comb begin
    mem_we = busy || upd_we;
    mem_wa = busy ? sweep_ptr : upd_wa;
    mem_wd = busy ? '0 : upd_wd;
  end

  prof_ram #(.AW(STATE_W), .DW(CNT_W)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .ra_addr(st_code), .ra_data(ra_q),
    .rb_addr(rd_addr), .rb_data(rb_q)
  );

  // Host read: a write landing on the read address this edge is forwarded.
  always_ff @(posedge clk) begin
    if (rst) rd_ack <= 1'b0;
    else     rd_ack <= rd_req;
    hit_q     <= mem_we && (mem_wa == rd_addr);
    hit_val_q <= mem_wd;
  end

  assign rd_data = hit_q ? hit_val_q : rb_q;

  AST_SWEEP_EXCL: assert property (@(posedge clk) disable iff (rst)
    busy |-> !upd_we) else $error("update during sweep"); // R6
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!counting && !clr_req) |=> $stable(cycle_total)) else $error("cycle count moved while halted"); // R5
  AST_RD_ACK: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_ack) else $error("read not acknowledged"); // R8
endmodule

// File: tb/test_state_occupancy_profiler.sv
module test_state_occupancy_profiler;
  import prof_pkg::*;

  localparam int SW   = 2;
  localparam int CW   = 8;
  localparam int YW   = 32;
  localparam int NS   = 1 << SW;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          st_valid = 1'b0;
  logic [SW-1:0] st_code = '0;
  logic          clr_req = 1'b0, halt_req = 1'b0, resume_req = 1'b0;
  logic          rd_req = 1'b0;
  logic [SW-1:0] rd_addr = '0;
  logic          rd_ack, busy, counting;
  logic [CW-1:0] rd_data;
  logic [YW-1:0] cycle_total;

  int n_run = 0;
  int n_bad = 0;
  int exp_cnt [NS];
  bit m_run = 1'b1;

  always #5 clk = ~clk;

  state_occupancy_profiler #(.STATE_W(SW), .CNT_W(CW), .CYC_W(YW)) i_state_occupancy_profiler (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_code(st_code),
    .clr_req(clr_req), .halt_req(halt_req), .resume_req(resume_req),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .cycle_total(cycle_total), .busy(busy), .counting(counting)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic step(input logic v, input int code);
    st_valid = v;
    st_code  = code[SW-1:0];
    @(negedge clk);
    if (v && m_run && exp_cnt[code] < MAXC) exp_cnt[code]++;
    st_valid = 1'b0;
  endtask

  task automatic step_rd(input string tag, input logic v, input int code, input int a);
    int e;
    e = exp_cnt[a];
    rd_req  = 1'b1;
    rd_addr = a[SW-1:0];
    step(v, code);
    rd_req = 1'b0;
    chk(tag, rd_data, e);
  endtask

  task automatic rd_check(input string tag, input int a);
    rd_req  = 1'b1;
    rd_addr = a[SW-1:0];
    @(negedge clk);
    rd_req = 1'b0;
    chk({tag, " ack"}, rd_ack, 1);
    chk(tag, rd_data, exp_cnt[a]);
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < NS; i++) rd_check(tag, i);
  endtask

  task automatic do_clear();
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    while (busy) @(negedge clk);
    for (int i = 0; i < NS; i++) exp_cnt[i] = 0;
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    chk("R7 cycle_total in reset", cycle_total, 0);
    chk("R7 rd_ack in reset", rd_ack, 0);
    rst = 1'b0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R7 busy length after reset", n, NS);
    chk("R7 counting after reset", counting, 1);
    for (int i = 0; i < NS; i++) exp_cnt[i] = 0;
    rd_all("R7 zero after reset");
  endtask

  task automatic t_basic();
    do_clear();
    step(1, int'(PC_IDLE));  step(1, int'(PC_INIT)); step(0, int'(PC_FLUSH));
    step(1, int'(PC_INIT));  step(1, int'(PC_RUN));  step(0, int'(PC_RUN));
    step(1, int'(PC_FLUSH)); step(0, int'(PC_FLUSH)); step(1, int'(PC_FLUSH));
    step(1, int'(PC_RUN));   step(0, 0); step(0, 0);
    rd_all("R1 R2 mixed pattern");
    chk("R2 flush tally ignores gaps", exp_cnt[3], 2);
  endtask

  task automatic t_forward();
    do_clear();
    step(1, 2); step(1, 2);
    step_rd("R8 read collides with write", 1, 2, 2);
    step(1, 2); step(1, 1); step(1, 2); step(1, 1);
    step_rd("R8 read during alternation", 1, 1, 1);
    step(1, 0); step(1, 0); step(1, 0);
    step(0, 0); step(0, 0);
    rd_all("R3 back-to-back and alternating");
    chk("R3 run tally", exp_cnt[2], 5);
  endtask

  task automatic t_sat();
    do_clear();
    for (int i = 0; i < MAXC + 45; i++) step(1, int'(PC_FLUSH));
    step(0, 0); step(0, 0);
    chk("R4 model saturated", exp_cnt[3], MAXC);
    rd_all("R4 saturation");
  endtask

  task automatic t_halt();
    logic [YW-1:0] ct;
    do_clear();
    step(1, 1); step(1, 1); step(1, 1);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    m_run = 1'b0;
    chk("R5 counting low", counting, 0);
    ct = cycle_total;
    for (int i = 0; i < 5; i++) step(1, 1);
    step(0, 0); step(0, 0);
    chk("R5 cycle_total frozen", cycle_total, ct);
    rd_check("R5 count frozen", 1);
    halt_req = 1'b1; resume_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0; resume_req = 1'b0;
    chk("R5 halt wins over resume", counting, 0);
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
    m_run = 1'b1;
    chk("R5 counting after resume", counting, 1);
    for (int i = 0; i < 4; i++) step(1, 1);
    step(0, 0); step(0, 0);
    rd_check("R5 counts after resume", 1);
  endtask

  task automatic t_cycles();
    do_clear();
    chk("R9 cycle_total zero after clear", cycle_total, 0);
    for (int i = 0; i < 4; i++) step(0, 0);
    for (int i = 0; i < 3; i++) step(1, 0);
    chk("R9 cycle_total counts all cycles", cycle_total, 7);
  endtask

  task automatic t_clear();
    int n;
    step(1, 2); step(1, 3); step(0, 0); step(0, 0);
    clr_req  = 1'b1;
    st_valid = 1'b1;
    st_code  = 2'd2;
    @(negedge clk);
    clr_req = 1'b0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    st_valid = 1'b0;
    chk("R6 busy length", n, NS);
    chk("R6 cycle_total cleared", cycle_total, 0);
    for (int i = 0; i < NS; i++) exp_cnt[i] = 0;
    rd_all("R6 counters cleared, states during sweep dropped");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) exp_cnt[i] = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_forward();
    t_sat();
    t_halt();
    t_cycles();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule